// File: doc/BRIEF.md
# Register-Exchange Viterbi Decoder

This block decodes a rate 1/2 convolutional code with constraint length 5, so the trellis has 16 states. It accepts one pair of soft-decision code symbols per handshake beat and emits one decoded bit for each accepted pair once the survivor window has filled. Hard decisions are fed as the two extreme soft values.

Each state holds its whole decoded-bit history in a survivor register. On every trellis step each state copies the register of the predecessor it selected and shifts the new decision bit in, and all states do this together. No traceback pass follows. Eight add-compare-select units serve the 16 states. Butterfly `j` joins old states `j` and `j+8` to new states `2j` and `2j+1`. The even new states are computed on the accept cycle and the odd ones on the following cycle, and then every state is committed at once. Path metrics are renormalised by subtracting the smallest metric, so they never wrap.

Top module: `vit_rx_decoder`

## Requirements
- R1: The code uses a 4-bit state. Bit 0 of the state is the most recent input bit. The next state is `{state[2:0], u}`. For the window `w = {state, u}`, symbol c0 is `^(w & 5'b10011)` and symbol c1 is `^(w & 5'b11101)`. `sym_i[SW-1:0]` carries c0 and `sym_i[2*SW-1:SW]` carries c1. A bit stream encoded from state 0 and received without errors decodes to the original bits.
- R2: Each branch metric adds two distances. The distance for an expected 0 is the received value, and the distance for an expected 1 is the maximum value minus the received value. With 3-bit symbols, isolated fully inverted symbols spaced well apart are corrected, and so are weakly wrong soft values.
- R3: Whenever the smallest new path metric reaches half of the metric range, it is subtracted from all 16 metrics. After a long run of ambiguous mid-scale symbols, a following clean coded stream still decodes correctly.
- R4: `sym_ready_o` drops for exactly one cycle after each accepted pair. Continuous input is therefore taken at one pair every two cycles.
- R5: No decoded bit appears until DEPTH pairs have been accepted. The n-th decoded bit (counting from 1) is the input bit of accepted pair n, where pairs are also counted from 1.
- R6: `bit_valid_o` is a one-cycle pulse on the clock edge that follows the accept edge of the pair that produced it. The bit is the oldest bit of the survivor of the state with the smallest metric, with the lowest index winning a tie.
- R7: After reset, `sym_ready_o` is 1 and `bit_valid_o` is 0. State 0 has metric 0, every other state has the maximum metric, and all survivors are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sym_valid_i | input | 1 | A symbol pair is offered |
| sym_ready_o | output | 1 | The decoder can take a pair |
| sym_i | input | 2*SW | Soft symbols: c0 in the low half, c1 in the high half |
| bit_valid_o | output | 1 | A decoded bit is present |
| bit_o | output | 1 | Decoded bit |

## Verification
A pair is accepted on the edge where `sym_valid_i` and `sym_ready_o` are both high. `sym_ready_o` is low from the next edge and high again one edge later. The decoded bit and its valid pulse appear one edge after the accept edge. They stay for one cycle and arrive DEPTH-1 pairs behind the input. The bench drives inputs and samples outputs on falling edges. It gathers every valid bit in arrival order and matches the n-th bit against message bit n. The directed fill test looks at the falling edges right after the DEPTH-th accept edge, one cycle apart, to pin the exact cycle of the first bit.

// File: rtl/vit_pkg.sv
`timescale 1ns/1ps
package vit_pkg;
  localparam int K  = 5;
  localparam int NS = 1 << (K - 1);
  localparam int NB = NS / 2;
  localparam logic [K-1:0] G0 = 5'b10011;
  localparam logic [K-1:0] G1 = 5'b11101;

  // expected {c1, c0} for window {state, u}
  function automatic logic [1:0] exp_pair(input logic [K-1:0] w);
    return {^(w & G1), ^(w & G0)};
  endfunction
endpackage

// File: rtl/vit_bmu.sv
`timescale 1ns/1ps
module vit_bmu #(
  parameter int SW = 3
) (
  input  logic [2*SW-1:0] sym_i,
  input  logic [1:0]      exp_i,
  output logic [SW:0]     bm_o
);
  localparam logic [SW-1:0] VMAX = '1;
  logic [SW-1:0] d0, d1;
  always_comb begin
    d0   = exp_i[0] ? VMAX - sym_i[SW-1:0]    : sym_i[SW-1:0];
    d1   = exp_i[1] ? VMAX - sym_i[2*SW-1:SW] : sym_i[2*SW-1:SW];
    bm_o = {1'b0, d0} + {1'b0, d1};
  end
endmodule

// File: rtl/vit_acs.sv
`timescale 1ns/1ps
module vit_acs
  import vit_pkg::*;
#(
  parameter int SW    = 3,
  parameter int MW    = 8,
  parameter int DEPTH = 25
) (
  input  logic [2*SW-1:0]  sym_i,
  input  logic [K-1:0]     wa_i,
  input  logic [K-1:0]     wb_i,
  input  logic [MW-1:0]    pm_a_i,
  input  logic [MW-1:0]    pm_b_i,
  input  logic [DEPTH-2:0] sv_a_i,
  input  logic [DEPTH-2:0] sv_b_i,
  input  logic             u_i,
  output logic [MW-1:0]    pm_o,
  output logic [DEPTH-1:0] sv_o
);
  logic [SW:0]   bm_a, bm_b;
  logic [MW:0]   sum_a, sum_b;
  logic [MW-1:0] sat_a, sat_b;
  logic          pick_b;

  vit_bmu #(.SW(SW)) u_bm_a (.sym_i(sym_i), .exp_i(exp_pair(wa_i)), .bm_o(bm_a));
  vit_bmu #(.SW(SW)) u_bm_b (.sym_i(sym_i), .exp_i(exp_pair(wb_i)), .bm_o(bm_b));

  always_comb begin
    sum_a  = {1'b0, pm_a_i} + {{(MW-SW){1'b0}}, bm_a};
    sum_b  = {1'b0, pm_b_i} + {{(MW-SW){1'b0}}, bm_b};
    sat_a  = sum_a[MW] ? '1 : sum_a[MW-1:0];
    sat_b  = sum_b[MW] ? '1 : sum_b[MW-1:0];
    pick_b = sat_b < sat_a;
    pm_o   = pick_b ? sat_b : sat_a;
    sv_o   = {pick_b ? sv_b_i : sv_a_i, u_i};
  end
endmodule

// File: rtl/vit_min.sv
`timescale 1ns/1ps
module vit_min #(
  parameter int N  = 16,
  parameter int MW = 8,
  localparam int IW = $clog2(N)
) (
  input  logic [MW-1:0] pm_i [N],
  output logic [IW-1:0] idx_o,
  output logic [MW-1:0] min_o
);
  always_comb begin
    idx_o = '0;
    min_o = pm_i[0];
    for (int i = 1; i < N; i++) begin
      if (pm_i[i] < min_o) begin
        min_o = pm_i[i];
        idx_o = IW'(i);
      end
    end
  end
endmodule

// File: rtl/vit_rx_decoder.sv
`timescale 1ns/1ps
module vit_rx_decoder
  import vit_pkg::*;
#(
  parameter int SW    = 3,
  parameter int MW    = 8,
  parameter int DEPTH = 25
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sym_valid_i,
  output logic          sym_ready_o,
  input  logic [2*SW-1:0] sym_i,
  output logic          bit_valid_o,
  output logic          bit_o
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int IW = $clog2(NS);

  logic              phase_q;
  logic [2*SW-1:0]   sym_q, sym_cur;
  logic [MW-1:0]     pm_q   [NS];
  logic [DEPTH-1:0]  sv_q   [NS];
  logic [MW-1:0]     shd_pm [NB];
  logic [DEPTH-1:0]  shd_sv [NB];
  logic [MW-1:0]     acs_pm [NB];
  logic [DEPTH-1:0]  acs_sv [NB];
  logic [MW-1:0]     new_pm [NS];
  logic [DEPTH-1:0]  new_sv [NS];
  logic [IW-1:0]     best_idx;
  logic [MW-1:0]     min_v;
  logic [MW-1:0]     sub_v;
  logic [CW-1:0]     cnt_q;

  assign sym_ready_o = ~phase_q;
  assign sym_cur     = phase_q ? sym_q : sym_i;

  // butterfly j: old j, j+8 -> new 2j (pass 0), 2j+1 (pass 1)
  for (genvar j = 0; j < NB; j++) begin : g_acs
    vit_acs #(.SW(SW), .MW(MW), .DEPTH(DEPTH)) u_acs (
      .sym_i  (sym_cur),
      .wa_i   ({4'(j), phase_q}),
      .wb_i   ({4'(j + NB), phase_q}),
      .pm_a_i (pm_q[j]),
      .pm_b_i (pm_q[j+NB]),
      .sv_a_i (sv_q[j][DEPTH-2:0]),
      .sv_b_i (sv_q[j+NB][DEPTH-2:0]),
      .u_i    (phase_q),
      .pm_o   (acs_pm[j]),
      .sv_o   (acs_sv[j])
    );
  end

  always_comb begin
    for (int j = 0; j < NB; j++) begin
      new_pm[2*j]   = shd_pm[j];
      new_sv[2*j]   = shd_sv[j];
      new_pm[2*j+1] = acs_pm[j];
      new_sv[2*j+1] = acs_sv[j];
    end
  end

  vit_min #(.N(NS), .MW(MW)) u_min (.pm_i(new_pm), .idx_o(best_idx), .min_o(min_v));

  assign sub_v = min_v[MW-1] ? min_v : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q     <= 1'b0;
      sym_q       <= '0;
      cnt_q       <= '0;
      bit_valid_o <= 1'b0;
      bit_o       <= 1'b0;
      for (int s = 0; s < NS; s++) begin
        pm_q[s] <= (s == 0) ? '0 : '1;
        sv_q[s] <= '0;
      end
      for (int j = 0; j < NB; j++) begin
        shd_pm[j] <= '0;
        shd_sv[j] <= '0;
      end
    end else begin
      bit_valid_o <= 1'b0;
      if (!phase_q && sym_valid_i) begin
        sym_q   <= sym_i;
        phase_q <= 1'b1;
        for (int j = 0; j < NB; j++) begin
          shd_pm[j] <= acs_pm[j];
          shd_sv[j] <= acs_sv[j];
        end
      end else if (phase_q) begin
        phase_q <= 1'b0;
        for (int s = 0; s < NS; s++) begin
          pm_q[s] <= new_pm[s] - sub_v;
          sv_q[s] <= new_sv[s];
        end
        if (cnt_q != CW'(DEPTH)) cnt_q <= cnt_q + 1'b1;
        bit_valid_o <= (cnt_q >= CW'(DEPTH - 1));
        bit_o       <= new_sv[best_idx][DEPTH-1];
      end
    end
  end
endmodule

// File: rtl/vit_chk.sv
`timescale 1ns/1ps
module vit_chk #(
  parameter int MW    = 8,
  parameter int DEPTH = 25
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          sym_valid_i,
  input logic          sym_ready_o,
  input logic          bit_valid_o,
  input logic [MW-1:0] pm_i [16]
);
  localparam int CW = $clog2(DEPTH + 1);
  logic [CW-1:0] acc_cnt;
  logic [MW-1:0] pm_min;
  logic          acc;

  assign acc = sym_valid_i && sym_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) acc_cnt <= '0;
    else if (acc && acc_cnt != CW'(DEPTH)) acc_cnt <= acc_cnt + 1'b1;
  end

  always_comb begin
    pm_min = pm_i[0];
    for (int i = 1; i < 16; i++) if (pm_i[i] < pm_min) pm_min = pm_i[i];
  end

  // R3
  norm_half_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pm_min < MW'(1 << (MW - 1)));
  // R4
  ready_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc |=> !sym_ready_o);
  // R4
  ready_back_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sym_ready_o |=> sym_ready_o);
  // R5
  fill_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_valid_o |-> acc_cnt == CW'(DEPTH));
  // R6
  out_timing_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_valid_o |-> $past(acc, 2));
  // R6
  out_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_valid_o |=> !bit_valid_o);
endmodule

bind vit_rx_decoder vit_chk #(.MW(MW), .DEPTH(DEPTH)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .sym_valid_i (sym_valid_i),
  .sym_ready_o (sym_ready_o),
  .bit_valid_o (bit_valid_o),
  .pm_i        (pm_q)
);

// File: tb/sim_vit_rx_decoder.sv
`timescale 1ns/1ps
module sim_vit_rx_decoder;
  localparam int SW    = 3;
  localparam int MW    = 8;
  localparam int DEPTH = 25;
  localparam int MLEN  = 40;
  localparam int NCASE = 6;
  localparam logic [SW-1:0] VMAX = '1;

  // per case: message, error gap in pairs (0 = none), mode (0 hard flip, 1 weak soft)
  localparam logic [MLEN-1:0] MSG [NCASE] = '{
    40'h0000000000, 40'hFFFFFFFFFF, 40'hA5C3_96F0_1E,
    40'h1234_5678_9A, 40'hDEAD_BEEF_42, 40'h0F0F_3C3C_81 };
  localparam int GAP  [NCASE] = '{0, 0, 0, 17, 20, 6};
  localparam int MODE [NCASE] = '{0, 0, 0, 0, 0, 1};

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic sym_valid_i = 1'b0;
  logic [2*SW-1:0] sym_i = '0;
  logic sym_ready_o, bit_valid_o, bit_o;

  int checks = 0, errors = 0;
  int nout = 0;
  logic outbuf [256];
  logic [3:0] est;

  always #2.5 clk = ~clk;

  vit_rx_decoder #(.SW(SW), .MW(MW), .DEPTH(DEPTH)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .sym_valid_i(sym_valid_i), .sym_ready_o(sym_ready_o),
    .sym_i(sym_i), .bit_valid_o(bit_valid_o), .bit_o(bit_o));

  always @(negedge clk) begin
    if (rst_ni && bit_valid_o && nout < 256) begin
      outbuf[nout] = bit_o;
      nout++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0;
    sym_valid_i = 1'b0;
    est = '0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    nout = 0;
  endtask

  // called at a falling edge; returns at the falling edge after the accept edge
  task automatic send(input logic [2*SW-1:0] v);
    sym_i = v;
    sym_valid_i = 1'b1;
    while (!sym_ready_o) @(negedge clk);
    @(negedge clk);
    sym_valid_i = 1'b0;
  endtask

  // R1 encoder model; err: 0 none, 1 invert c0, 2 weak both
  task automatic enc_send(input logic u, input int err);
    logic [4:0] w;
    logic c0, c1;
    logic [SW-1:0] v0, v1;
    w  = {est, u};
    c0 = ^(w & 5'b10011);
    c1 = ^(w & 5'b11101);
    est = {est[2:0], u};
    v0 = c0 ? VMAX : '0;
    v1 = c1 ? VMAX : '0;
    if (err == 1) v0 = VMAX - v0;
    if (err == 2) begin
      v0 = c0 ? SW'(3) : SW'(4);
      v1 = c1 ? SW'(3) : SW'(4);
    end
    send({v1, v0});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R7 reset state
    do_reset();
    chk(sym_ready_o == 1'b1, "R7 ready after reset", sym_ready_o, 1);
    chk(bit_valid_o == 1'b0, "R7 valid after reset", bit_valid_o, 0);

    // R1 R2 vector table
    for (int c = 0; c < NCASE; c++) begin
      int bad;
      do_reset();
      for (int i = 0; i < MLEN + DEPTH - 1; i++) begin
        logic u;
        int e;
        u = (i < MLEN) ? MSG[c][i] : 1'b0;
        e = 0;
        if (GAP[c] != 0 && (i % GAP[c]) == GAP[c] / 2) e = MODE[c] ? 2 : 1;
        enc_send(u, e);
      end
      repeat (4) @(negedge clk);
      chk(nout == MLEN, "R5 output count", nout, MLEN);
      bad = 0;
      for (int i = 0; i < MLEN; i++) begin
        if (outbuf[i] !== MSG[c][i]) begin
          bad++;
          chk(1'b0, (GAP[c] == 0) ? "R1 clean decode" : "R2 error correction",
              outbuf[i], MSG[c][i]);
        end
      end
      chk(bad == 0, "R1 R2 case bits", bad, 0);
    end

    // R4 ready drops one cycle after accept, back the next
    do_reset();
    sym_i = '0;
    sym_valid_i = 1'b1;
    @(negedge clk);
    chk(sym_ready_o == 1'b0, "R4 ready low after accept", sym_ready_o, 0);
    @(negedge clk);
    chk(sym_ready_o == 1'b1, "R4 ready back", sym_ready_o, 1);
    @(negedge clk);
    chk(sym_ready_o == 1'b0, "R4 second accept at 2-cycle rate", sym_ready_o, 0);
    sym_valid_i = 1'b0;
    @(negedge clk);

    // R5 R6 fill and exact output timing
    do_reset();
    for (int i = 0; i < DEPTH - 1; i++) enc_send(1'b1, 0);
    repeat (3) @(negedge clk);
    chk(nout == 0, "R5 no output before fill", nout, 0);
    sym_i = '0;
    sym_valid_i = 1'b1;
    @(negedge clk);
    sym_valid_i = 1'b0;
    chk(bit_valid_o == 1'b0, "R6 not in accept cycle", bit_valid_o, 0);
    @(negedge clk);
    chk(bit_valid_o == 1'b1, "R6 valid one edge after accept", bit_valid_o, 1);
    chk(bit_o == 1'b1, "R5 first bit equals first input", bit_o, 1);
    @(negedge clk);
    chk(bit_valid_o == 1'b0, "R6 single-cycle pulse", bit_valid_o, 0);

    // R3 long ambiguous run forces renormalisation, then clean stream
    do_reset();
    for (int i = 0; i < 100; i++) send({SW'(3), SW'(3)});
    est = '0;
    for (int i = 0; i < MLEN + DEPTH - 1; i++)
      enc_send((i < MLEN) ? MSG[2][i] : 1'b0, 0);
    repeat (4) @(negedge clk);
    chk(nout == 100 + MLEN, "R3 output count", nout, 100 + MLEN);
    begin
      int bad;
      bad = 0;
      for (int i = 0; i < MLEN; i++) if (outbuf[100 + i] !== MSG[2][i]) bad++;
      chk(bad == 0, "R3 decode after renormalisation", bad, 0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule